// File: doc/BRIEF.md
# PHY Analog Power-Up Sequencer

This block runs the power-up and power-down sequence of a storage-interface PHY without software stepping through it. A single-cycle command requests either power-on or power-off. The block first parks the analog front end: power-down-bar low and the delay-locked loop (DLL) disabled. A power-off request finishes at that point. A power-on request then continues through timed settling waits. It checks the calibration status once, programs the DLL frequency band, enables the DLL and polls for lock.

All waits are counted in microseconds. One microsecond is a parameterised number of reference-clock cycles. The card-clock rate in Hz is supplied by another block. The sequencer turns that rate into a two-bit band code and raises a warning when the rate lies too far from the band it selected. The analog calibration cell and the DLL appear here only as their two status inputs.

Each sequence ends with a one-cycle event pulse of one of three kinds: success, calibration timeout or lock timeout. A sticky copy of that result stays visible until the next command is accepted.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, pdb, dll_en, busy, every event pulse, every sticky flag and rate_warn are 0, and freq_sel is 0.
- R2: An accepted command drives pdb and dll_en low. A power-off command then ends with a success event while both outputs stay low.
- R3: On power-on, freq_sel is set from the latched rate. The code is 1 (50 MHz band) for 1 to 74,999,999 Hz, 2 (100 MHz band) for 75,000,000 to 124,999,999 Hz, 3 (150 MHz band) for 125,000,000 to 174,999,999 Hz, and 0 (200 MHz band) for any higher rate and for a rate of 0.
- R4: rate_warn is set for a power-on whose rate exceeds 200 MHz. It is also set when the rate exceeds 50 MHz and lies more than 15 MHz from the nominal rate of the chosen band. Otherwise it is 0.
- R5: pdb rises no earlier than PRE_US microseconds after the parking phase.
- R6: Calibration-done is sampled once, CAL_US microseconds after pdb rises. If it is low, the sequence ends with a calibration-timeout event, and dll_en stays low and freq_sel keeps its previous value.
- R7: freq_sel is written one cycle before dll_en rises, and does not change on that cycle.
- R8: With a rate of 0, the sequence ends with a success event right after dll_en rises, without waiting for DLL ready.
- R9: With a nonzero rate, DLL ready is sampled once per microsecond. A high sample ends the sequence with success. If no sample is high within DLL_TO_US microseconds, the sequence ends with a lock-timeout event, with pdb and dll_en left high.
- R10: Commands that arrive while busy is high have no effect on the running sequence or its result.
- R11: Each event is a pulse of exactly one cycle, and at most one event is high at a time. The matching sticky flag and rate_warn hold until the next command is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | 1 | Request power-on sequence (wins over cmd_off) |
| cmd_off | input | 1 | Request power-off sequence |
| rate_hz | input | 32 | Measured card-clock rate in Hz, latched at acceptance |
| cal_done | input | 1 | Calibration-complete status from the analog cell |
| dll_ready | input | 1 | DLL lock status |
| pdb | output | 1 | Power-down-bar to the analog blocks |
| dll_en | output | 1 | DLL enable |
| freq_sel | output | 2 | DLL frequency band code |
| busy | output | 1 | A sequence is running |
| evt_done | output | 1 | One-cycle success pulse |
| evt_cal_to | output | 1 | One-cycle calibration-timeout pulse |
| evt_dll_to | output | 1 | One-cycle lock-timeout pulse |
| sts_done | output | 1 | Sticky success flag |
| sts_cal_to | output | 1 | Sticky calibration-timeout flag |
| sts_dll_to | output | 1 | Sticky lock-timeout flag |
| rate_warn | output | 1 | Sticky unsupported-rate warning |

## Verification
Several properties are checked on every cycle, in whichever state the machine is in:

- pdb and dll_en are low during parking.
- The time spent in each wait state meets its microsecond floor before pdb rises, before calibration is judged and before a lock timeout is declared.
- freq_sel is stable when dll_en rises.
- Event pulses last one cycle and are mutually exclusive.
- Busy-time commands never restart the sequence.

Other behaviours can only be shown by the bench's scenarios:

- The band and warning mapping at each range edge.
- The choice between success and each error under given status inputs.
- The zero-rate shortcut.
- That the sticky flags clear on the next accepted command.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int RATE_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARK,
        ST_PRE,
        ST_CAL,
        ST_DLL_ON,
        ST_POLL
    } seq_state_e;

    typedef enum logic [1:0] {
        BAND_200 = 2'd0,
        BAND_50  = 2'd1,
        BAND_100 = 2'd2,
        BAND_150 = 2'd3
    } band_e;

    typedef struct packed {
        band_e band;
        logic  warn;
    } rate_info_t;

    typedef struct packed {
        logic done;
        logic cal_to;
        logic dll_to;
    } seq_evt_t;

    localparam logic [RATE_W-1:0] HZ_50M   = 32'd50_000_000;
    localparam logic [RATE_W-1:0] HZ_75M   = 32'd75_000_000;
    localparam logic [RATE_W-1:0] HZ_100M  = 32'd100_000_000;
    localparam logic [RATE_W-1:0] HZ_125M  = 32'd125_000_000;
    localparam logic [RATE_W-1:0] HZ_150M  = 32'd150_000_000;
    localparam logic [RATE_W-1:0] HZ_175M  = 32'd175_000_000;
    localparam logic [RATE_W-1:0] HZ_200M  = 32'd200_000_000;
    localparam logic [RATE_W-1:0] HZ_TOL   = 32'd15_000_000;

    // Band selection plus off-nominal check for one rate.
    function automatic rate_info_t classify_rate(input logic [RATE_W-1:0] r);
        rate_info_t        res;
        logic [RATE_W-1:0] nom;
        logic [RATE_W-1:0] diff;
        if (r == '0) begin
            res.band = BAND_200;
            nom      = HZ_200M;
        end else if (r < HZ_75M) begin
            res.band = BAND_50;
            nom      = HZ_50M;
        end else if (r < HZ_125M) begin
            res.band = BAND_100;
            nom      = HZ_100M;
        end else if (r < HZ_175M) begin
            res.band = BAND_150;
            nom      = HZ_150M;
        end else begin
            res.band = BAND_200;
            nom      = HZ_200M;
        end
        diff     = (r > nom) ? (r - nom) : (nom - r);
        res.warn = (r > HZ_200M) || ((r > HZ_50M) && (diff > HZ_TOL));
        return res;
    endfunction

endpackage

// File: rtl/phy_seq_rate_class.sv
module phy_seq_rate_class
    import phy_seq_pkg::*;
(
    input  logic [RATE_W-1:0] rate,
    output rate_info_t        info
);
    always_comb begin
        info = classify_rate(rate);
    end
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int CYC_PER_US = 100,
    parameter int US_W       = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    output logic            tick,
    output logic [US_W-1:0] us_count
);
    localparam int CYC_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_US - 1);

    logic [CYC_W-1:0] cyc_q;

    assign tick = (cyc_q == CYC_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cyc_q    <= '0;
            us_count <= '0;
        end else if (tick) begin
            cyc_q <= '0;
            if (us_count != '1) begin
                us_count <= us_count + 1'b1;
            end
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    p_cyc_range_r5: assert property (@(posedge clk) disable iff (rst)
        cyc_q <= CYC_LAST);
endmodule

// File: rtl/phy_seq_status.sv
module phy_seq_status
    import phy_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  seq_evt_t fin,
    input  logic     warn_ld,
    input  logic     warn_val,
    output seq_evt_t evt,
    output seq_evt_t sts,
    output logic     warn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt  <= '0;
            sts  <= '0;
            warn <= 1'b0;
        end else begin
            evt <= fin;
            if (clr) begin
                sts  <= '0;
                warn <= 1'b0;
            end else begin
                sts <= sts | fin;
                if (warn_ld) begin
                    warn <= warn_val;
                end
            end
        end
    end

    p_one_event_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.done, evt.cal_to, evt.dll_to}));
    p_pulse_short_r11: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> (evt == '0));
    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (evt.done && !clr) |=> sts.done);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_seq_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int PRE_US     = 3,
    parameter int CAL_US     = 5,
    parameter int DLL_TO_US  = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_on,
    input  logic              cmd_off,
    input  logic [RATE_W-1:0] rate_hz,
    input  logic              cal_done,
    input  logic              dll_ready,
    output logic              pdb,
    output logic              dll_en,
    output logic [1:0]        freq_sel,
    output logic              busy,
    output logic              evt_done,
    output logic              evt_cal_to,
    output logic              evt_dll_to,
    output logic              sts_done,
    output logic              sts_cal_to,
    output logic              sts_dll_to,
    output logic              rate_warn
);
    localparam int US_MAX0 = (PRE_US > CAL_US) ? PRE_US : CAL_US;
    localparam int US_MAX  = (DLL_TO_US > US_MAX0) ? DLL_TO_US : US_MAX0;
    localparam int US_W    = $clog2(US_MAX + 1);
    localparam logic [US_W-1:0] PRE_LAST = US_W'(PRE_US - 1);
    localparam logic [US_W-1:0] CAL_LAST = US_W'(CAL_US - 1);
    localparam logic [US_W-1:0] DLL_LAST = US_W'(DLL_TO_US - 1);

    seq_state_e        state_q, state_d;
    logic [RATE_W-1:0] rate_q;
    logic              want_on_q;
    band_e             band_q, band_d;
    logic              pdb_d, dll_d;
    logic              restart;
    logic              tick;
    logic [US_W-1:0]   us_count;
    logic              accept;
    logic              warn_ld;
    seq_evt_t          fin;
    seq_evt_t          evt;
    seq_evt_t          sts;
    rate_info_t        info;

    assign accept = (state_q == ST_IDLE) && (cmd_on || cmd_off);
    assign busy   = (state_q != ST_IDLE);

    phy_seq_timer #(
        .CYC_PER_US (CYC_PER_US),
        .US_W       (US_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .tick     (tick),
        .us_count (us_count)
    );

    phy_seq_rate_class u_rate (
        .rate (rate_q),
        .info (info)
    );

    phy_seq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .fin      (fin),
        .warn_ld  (warn_ld),
        .warn_val (info.warn),
        .evt      (evt),
        .sts      (sts),
        .warn     (rate_warn)
    );

    always_comb begin
        state_d = state_q;
        pdb_d   = pdb;
        dll_d   = dll_en;
        band_d  = band_q;
        restart = 1'b0;
        warn_ld = 1'b0;
        fin     = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    pdb_d   = 1'b0;
                    dll_d   = 1'b0;
                    state_d = ST_PARK;
                end
            end
            ST_PARK: begin
                if (!want_on_q) begin
                    fin.done = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    warn_ld = 1'b1;
                    restart = 1'b1;
                    state_d = ST_PRE;
                end
            end
            ST_PRE: begin
                if (tick && (us_count == PRE_LAST)) begin
                    pdb_d   = 1'b1;
                    restart = 1'b1;
                    state_d = ST_CAL;
                end
            end
            ST_CAL: begin
                if (tick && (us_count == CAL_LAST)) begin
                    if (cal_done) begin
                        band_d  = info.band;
                        state_d = ST_DLL_ON;
                    end else begin
                        fin.cal_to = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            ST_DLL_ON: begin
                dll_d = 1'b1;
                if (rate_q == '0) begin
                    fin.done = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    restart = 1'b1;
                    state_d = ST_POLL;
                end
            end
            ST_POLL: begin
                if (tick) begin
                    if (dll_ready) begin
                        fin.done = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (us_count == DLL_LAST) begin
                        fin.dll_to = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pdb       <= 1'b0;
            dll_en    <= 1'b0;
            band_q    <= BAND_200;
            rate_q    <= '0;
            want_on_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pdb     <= pdb_d;
            dll_en  <= dll_d;
            band_q  <= band_d;
            if (accept) begin
                rate_q    <= rate_hz;
                want_on_q <= cmd_on;
            end
        end
    end

    assign freq_sel   = band_q;
    assign evt_done   = evt.done;
    assign evt_cal_to = evt.cal_to;
    assign evt_dll_to = evt.dll_to;
    assign sts_done   = sts.done;
    assign sts_cal_to = sts.cal_to;
    assign sts_dll_to = sts.dll_to;

    // Cycle counters used only by the timing properties below.
    logic [31:0] pre_cyc, cal_cyc, poll_cyc;
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cyc  <= '0;
            cal_cyc  <= '0;
            poll_cyc <= '0;
        end else begin
            pre_cyc  <= (state_q == ST_PRE)  ? pre_cyc + 1  : ((state_q == ST_PARK) ? '0 : pre_cyc);
            cal_cyc  <= (state_q == ST_CAL)  ? cal_cyc + 1  : '0;
            poll_cyc <= (state_q == ST_POLL) ? poll_cyc + 1 : '0;
        end
    end

    p_park_low_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PARK) |-> (!pdb && !dll_en));
    p_pre_wait_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pdb) |-> (pre_cyc >= 32'(PRE_US * CYC_PER_US)));
    p_cal_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAL && state_d != ST_CAL) |-> (cal_cyc + 1 >= 32'(CAL_US * CYC_PER_US)));
    p_freq_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(dll_en) |-> $stable(freq_sel));
    p_dll_after_pdb_r6: assert property (@(posedge clk) disable iff (rst)
        dll_en |-> pdb);
    p_lock_window_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && evt_dll_to == 1'b0 && state_d == ST_IDLE && !dll_ready)
        |-> (poll_cyc + 1 >= 32'(DLL_TO_US * CYC_PER_US)));
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q != ST_PARK && (cmd_on || cmd_off)) |=> (state_q != ST_PARK));
endmodule

// File: tb/test_phy_pwr_seq.sv
module test_phy_pwr_seq;
    localparam int C   = 4;
    localparam int PRE = 3;
    localparam int CAL = 5;
    localparam int DTO = 20;

    typedef struct {
        int         kind;
        logic [1:0] freq;
        logic       warn;
        logic       pdb;
        logic       dll;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_on = 1'b0;
    logic        cmd_off = 1'b0;
    logic [31:0] rate_hz = '0;
    logic        cal_done = 1'b0;
    logic        dll_ready = 1'b0;
    logic        pdb, dll_en, busy;
    logic [1:0]  freq_sel;
    logic        evt_done, evt_cal_to, evt_dll_to;
    logic        sts_done, sts_cal_to, sts_dll_to, rate_warn;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];
    logic [1:0] cur_freq = 2'd0;

    always #4 clk = ~clk;

    phy_pwr_seq #(
        .CYC_PER_US (C),
        .PRE_US     (PRE),
        .CAL_US     (CAL),
        .DLL_TO_US  (DTO)
    ) i_phy_pwr_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_on     (cmd_on),
        .cmd_off    (cmd_off),
        .rate_hz    (rate_hz),
        .cal_done   (cal_done),
        .dll_ready  (dll_ready),
        .pdb        (pdb),
        .dll_en     (dll_en),
        .freq_sel   (freq_sel),
        .busy       (busy),
        .evt_done   (evt_done),
        .evt_cal_to (evt_cal_to),
        .evt_dll_to (evt_dll_to),
        .sts_done   (sts_done),
        .sts_cal_to (sts_cal_to),
        .sts_dll_to (sts_dll_to),
        .rate_warn  (rate_warn)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per event pulse.
    always @(negedge clk) begin
        if (!rst && (evt_done || evt_cal_to || evt_dll_to)) begin
            int   kind;
            exp_t e;
            kind = evt_done ? 0 : (evt_cal_to ? 1 : 2);
            check((32'(evt_done) + 32'(evt_cal_to) + 32'(evt_dll_to)) == 1,
                  "R11", "single event", evt_done + evt_cal_to + evt_dll_to, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected event", kind, -1);
            end else begin
                e = exp_q.pop_front();
                check(kind == e.kind, "R9", "event kind", kind, e.kind);
                check(freq_sel == e.freq, "R3", "freq_sel", freq_sel, e.freq);
                check(rate_warn == e.warn, "R4", "rate_warn", rate_warn, e.warn);
                check(pdb == e.pdb, "R6", "pdb at end", pdb, e.pdb);
                check(dll_en == e.dll, "R8", "dll_en at end", dll_en, e.dll);
            end
        end
    end

    task automatic run_seq(input bit on, input logic [31:0] rate, input bit cal,
                           input bit dll, input int kind, input logic [1:0] freq,
                           input bit warn, input bit epdb, input bit edll,
                           output int t_pdb, output int t_dll, output int t_end);
        exp_t       e;
        int         n;
        logic [1:0] prev;
        @(negedge clk);
        cmd_on    = on;
        cmd_off   = !on;
        rate_hz   = rate;
        cal_done  = cal;
        dll_ready = dll;
        e.kind = kind; e.freq = freq; e.warn = warn; e.pdb = epdb; e.dll = edll;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_on  = 1'b0;
        cmd_off = 1'b0;
        n = 1;
        check(busy == 1'b1, "R10", "busy after accept", busy, 1);
        check({sts_done, sts_cal_to, sts_dll_to, rate_warn} == 4'b0, "R11",
              "sticky cleared on accept", {sts_done, sts_cal_to, sts_dll_to, rate_warn}, 0);
        check(!pdb && !dll_en, "R2", "parked low", {pdb, dll_en}, 0);
        t_pdb = -1;
        t_dll = -1;
        prev  = freq_sel;
        while (busy) begin
            @(negedge clk);
            n++;
            if (pdb && t_pdb < 0) t_pdb = n;
            if (dll_en && t_dll < 0) begin
                t_dll = n;
                check(freq_sel == prev, "R7", "freq stable at dll_en rise", freq_sel, prev);
            end
            prev = freq_sel;
        end
        t_end = n;
        if (kind == 0) check(sts_done, "R11", "sticky done", sts_done, 1);
        if (kind == 1) check(sts_cal_to, "R11", "sticky cal", sts_cal_to, 1);
        if (kind == 2) check(sts_dll_to, "R11", "sticky dll", sts_dll_to, 1);
        @(negedge clk);
        check(!(evt_done || evt_cal_to || evt_dll_to), "R11", "pulse one cycle",
              evt_done | evt_cal_to | evt_dll_to, 0);
        check(rate_warn == warn, "R11", "warn held", rate_warn, warn);
        if (kind == 0 && on) cur_freq = freq;
    endtask

    task automatic rate_case(input logic [31:0] rate, input logic [1:0] freq, input bit warn);
        int a, b, c;
        run_seq(1'b1, rate, 1'b1, 1'b1, 0, freq, warn, 1'b1, 1'b1, a, b, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int tp, td, te;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({pdb, dll_en, busy, freq_sel} == 5'b0, "R1", "reset outputs",
              {pdb, dll_en, busy, freq_sel}, 0);
        check({evt_done, evt_cal_to, evt_dll_to, sts_done, sts_cal_to, sts_dll_to, rate_warn} == 7'b0,
              "R1", "reset flags", {sts_done, sts_cal_to, sts_dll_to, rate_warn}, 0);

        // R2 power-off
        run_seq(1'b0, 32'd100_000_000, 1'b1, 1'b1, 0, 2'd0, 1'b0, 1'b0, 1'b0, tp, td, te);
        check(tp < 0 && td < 0, "R2", "off keeps low", tp, -1);

        // R3/R5 nominal power-on with timing
        run_seq(1'b1, 32'd100_000_000, 1'b1, 1'b1, 0, 2'd2, 1'b0, 1'b1, 1'b1, tp, td, te);
        check(tp >= PRE * C && tp <= PRE * C + 3, "R5", "pdb delay", tp, PRE * C + 2);
        check(td - tp >= CAL * C, "R6", "cal wait", td - tp, CAL * C);

        // R3/R4 band edges and warnings
        rate_case(32'd40_000_000, 2'd1, 1'b0);
        rate_case(32'd30_000_000, 2'd1, 1'b0);
        rate_case(32'd74_999_999, 2'd1, 1'b1);
        rate_case(32'd75_000_000, 2'd2, 1'b1);
        rate_case(32'd124_999_999, 2'd2, 1'b1);
        rate_case(32'd125_000_000, 2'd3, 1'b1);
        rate_case(32'd160_000_000, 2'd3, 1'b0);
        rate_case(32'd130_000_000, 2'd3, 1'b1);
        rate_case(32'd175_000_000, 2'd0, 1'b1);
        rate_case(32'd200_000_000, 2'd0, 1'b0);
        rate_case(32'd210_000_000, 2'd0, 1'b1);
        rate_case(32'd110_000_000, 2'd2, 1'b0);

        // R6 calibration timeout keeps previous freq, dll off
        run_seq(1'b1, 32'd50_000_000, 1'b0, 1'b1, 1, cur_freq, 1'b0, 1'b1, 1'b0, tp, td, te);
        check(td < 0, "R6", "dll stays off", td, -1);
        check(te - tp >= CAL * C, "R6", "cal sample time", te - tp, CAL * C);

        // R8 zero rate: done without lock
        run_seq(1'b1, 32'd0, 1'b1, 1'b0, 0, 2'd0, 1'b0, 1'b1, 1'b1, tp, td, te);
        check(te - td <= 1, "R8", "no lock wait", te - td, 1);

        // R9 lock timeout
        run_seq(1'b1, 32'd150_000_000, 1'b1, 1'b0, 2, 2'd3, 1'b0, 1'b1, 1'b1, tp, td, te);
        check(te - td >= DTO * C && te - td <= DTO * C + 3, "R9", "lock timeout window",
              te - td, DTO * C);

        // R10 commands while busy are ignored
        begin
            exp_t e;
            @(negedge clk);
            cmd_on = 1'b1; rate_hz = 32'd100_000_000; cal_done = 1'b1; dll_ready = 1'b1;
            e.kind = 0; e.freq = 2'd2; e.warn = 1'b0; e.pdb = 1'b1; e.dll = 1'b1;
            exp_q.push_back(e);
            @(negedge clk);
            cmd_on = 1'b0;
            repeat (3) @(negedge clk);
            cmd_off = 1'b1;
            @(negedge clk);
            cmd_off = 1'b0;
            repeat (PRE * C) @(negedge clk);
            check(pdb == 1'b1, "R10", "pdb not dropped by busy cmd", pdb, 1);
            while (busy) @(negedge clk);
            check(pdb && dll_en && sts_done, "R10", "sequence completed",
                  {pdb, dll_en, sts_done}, 7);
            @(negedge clk);
        end

        check(exp_q.size() == 0, "R11", "all events seen", exp_q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule